// File: doc/BRIEF.md
# Global Exposure Trigger and Strobe Sequencer

This block times one capture of a global-shutter pixel array. A start event comes from one of three sources: the rising edge of an external trigger, the rising edge of a frame-sync input, or an internal free-running frame period. The start event launches a fixed run of phases. First comes one exposure window that every row shares. Next comes a hold interval in which the stored charge waits. Last comes a readout scan of a set number of lines. Single-cycle pulses mark three instants: exposure begin, exposure end (the transfer into storage) and the move from storage to readout. Frame and line sync levels frame the readout scan.

A strobe window is placed against the exposure window by a signed cycle offset and an unsigned width. A negative offset places the strobe ahead of exposure, which delays exposure by that many cycles. The strobe is cut at exposure end unless a mode bit lets it run on. All timing values are written into staged registers through a simple write port. They are copied into working registers at each sequence start, so a write made mid-frame affects only the next frame. A start event that arrives while a sequence is running is dropped, and it sets a sticky flag and increments a saturating counter.

Top module: `gsx_seq`

## Requirements
- R1: With mode bits 0 and 1 clear, a rising trig_i starts a sequence. expo_o first reads high after the third rising clock edge, counting the edge that first samples trig_i high, plus any lead cycles from R6.
- R2: The phases run in a fixed order. Exposure lasts E cycles (address 1), hold lasts H cycles (address 2), and readout lasts N x (P + B) cycles (N at address 5, P at address 6, B at address 7). Then the block is idle and busy_o is low. A value of zero in E, H, N or P is treated as one.
- R3: exp_start_o is high only in the first exposure cycle, exp_stop_o only in the first hold cycle, and rd_xfer_o only in the first readout cycle.
- R4: vsync_o is high for the whole readout. hsync_o is high for the first P cycles of every P + B cycle line period and low for the B blanking cycles.
- R5: The strobe offset O (address 3, two's complement) and width W (address 4) place strobe_o. With O >= 0, strobe_o is high from exposure cycle O for W cycles.
- R6: With O < 0, exposure starts |O| cycles after the sequence start, and strobe_o is high from the sequence start for W cycles.
- R7: With mode bit 2 clear, strobe_o never stays high past the last exposure cycle. With it set, strobe_o runs its full width but ends no later than the end of the sequence.
- R8: A start event while busy_o is high neither restarts nor alters the running sequence. It sets ovr_flag_o, which stays set until reset, and adds one to ovr_cnt_o, which saturates.
- R9: With mode bit 1 set, a rising fsync_i starts a sequence with the latency of R1, and trig_i has no effect.
- R10: With mode bit 0 set, a sequence starts every F cycles (address 8). The first start comes F clock edges after the edge that writes the mode bit.
- R11: Writes to addresses 1 to 7 and to mode bit 2 during a sequence do not change that sequence. They apply from the next sequence start.
- R12: After reset, every timing output is low and ovr_cnt_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | External capture trigger, asynchronous |
| fsync_i | input | 1 | Frame-sync input, asynchronous |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address (0 mode, 1 to 8 timing values) |
| cfg_wdata_i | input | CW | Register write data |
| expo_o | output | 1 | Global exposure window |
| exp_start_o | output | 1 | Exposure begin pulse |
| exp_stop_o | output | 1 | Exposure end / transfer into storage pulse |
| rd_xfer_o | output | 1 | Storage-to-readout transfer pulse |
| vsync_o | output | 1 | Frame sync, high through readout |
| hsync_o | output | 1 | Line sync, high for active pixels |
| strobe_o | output | 1 | Strobe window |
| busy_o | output | 1 | Sequence in progress |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| ovr_cnt_o | output | OVW | Saturating count of dropped start events |

## Verification
A trigger or frame-sync edge driven between two clock edges produces its first exposure cycle three clock edges later. The bench therefore samples that cycle at the third falling edge after the drive. From that falling edge on, it compares every output on every cycle against a per-cycle model that is built only from the programmed lengths and offsets. A dropped start counts on the third edge after its drive, and a free-running start comes F edges after the mode write. Each of these checks samples on the falling edge right after the rising edge that is due to change the output, and it also checks the cycle just before.

// File: rtl/gsx_pkg.sv
package gsx_pkg;
   localparam int REG_AW    = 4;
   localparam int REG_MODE  = 0;
   localparam int REG_EXP   = 1;
   localparam int REG_HOLD  = 2;
   localparam int REG_SOFF  = 3;
   localparam int REG_SWID  = 4;
   localparam int REG_LINES = 5;
   localparam int REG_PIX   = 6;
   localparam int REG_HBLK  = 7;
   localparam int REG_PER   = 8;

   localparam int MB_FREE   = 0;
   localparam int MB_FSRC   = 1;
   localparam int MB_SALLOW = 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_EXPO,
      PH_HOLD,
      PH_READ
   } gsx_phase_e;
endpackage

// File: rtl/gsx_sync.sv
module gsx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gsx_sync: STAGES must be at least 2");
   end

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_i};
   end

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/gsx_regs.sv
module gsx_regs import gsx_pkg::*; #(
   parameter int CW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [CW-1:0]     wdata_i,
   input  logic              load_i,
   output logic              stg_free_o,
   output logic              stg_fsrc_o,
   output logic [CW-1:0]     stg_per_o,
   output logic              stg_lead_o,
   output logic              act_allow_o,
   output logic [CW-1:0]     act_exp_o,
   output logic [CW-1:0]     act_hold_o,
   output logic [CW-1:0]     act_soff_o,
   output logic [CW-1:0]     act_swid_o,
   output logic [CW-1:0]     act_lines_o,
   output logic [CW-1:0]     act_pix_o,
   output logic [CW-1:0]     act_hblk_o
);
   if (CW < 4) begin : g_bad_cw
      $error("gsx_regs: CW must be at least 4");
   end

   function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
      return (v == '0) ? CW'(1) : v;
   endfunction

   logic [2:0] mode_q;
   logic       allow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else if (we_i && addr_i == REG_AW'(REG_MODE)) mode_q <= wdata_i[2:0];
   end

   // staged copies, written at any time
   for (genvar i = REG_EXP; i <= REG_PER; i++) begin : g_stg
      logic [CW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (we_i && addr_i == REG_AW'(i)) q <= wdata_i;
      end
   end

   // working copies, refreshed only at a sequence start
   for (genvar i = REG_EXP; i <= REG_HBLK; i++) begin : g_act
      logic [CW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= '0;
         else if (load_i) q <= g_stg[i].q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      allow_q <= 1'b0;
      else if (load_i) allow_q <= mode_q[MB_SALLOW];
   end

   assign stg_free_o  = mode_q[MB_FREE];
   assign stg_fsrc_o  = mode_q[MB_FSRC];
   assign stg_per_o   = at_least_one(g_stg[REG_PER].q);
   assign stg_lead_o  = g_stg[REG_SOFF].q[CW-1];
   assign act_allow_o = allow_q;
   assign act_exp_o   = at_least_one(g_act[REG_EXP].q);
   assign act_hold_o  = at_least_one(g_act[REG_HOLD].q);
   assign act_soff_o  = g_act[REG_SOFF].q;
   assign act_swid_o  = g_act[REG_SWID].q;
   assign act_lines_o = at_least_one(g_act[REG_LINES].q);
   assign act_pix_o   = at_least_one(g_act[REG_PIX].q);
   assign act_hblk_o  = g_act[REG_HBLK].q;
endmodule

// File: rtl/gsx_strobe.sv
module gsx_strobe #(
   parameter int CW  = 16,
   parameter int TLW = CW + 3
) (
   input  logic [TLW-1:0] tl_i,
   input  logic           busy_i,
   input  logic [CW-1:0]  exp_len_i,
   input  logic [CW-1:0]  soff_i,
   input  logic [CW-1:0]  swid_i,
   input  logic           allow_i,
   output logic [CW:0]    lead_o,
   output logic           strobe_o
);
   if (TLW < CW + 3) begin : g_bad_tlw
      $error("gsx_strobe: TLW must be at least CW+3");
   end

   logic           neg;
   logic [CW:0]    off_x;
   logic [TLW-1:0] beg_t, end_raw, exp_end, end_t;

   always_comb begin
      neg     = soff_i[CW-1];
      off_x   = {soff_i[CW-1], soff_i};
      lead_o  = neg ? -off_x : '0;
      beg_t   = neg ? '0 : TLW'(soff_i);
      end_raw = beg_t + TLW'(swid_i);
      exp_end = TLW'(lead_o) + TLW'(exp_len_i);
      end_t   = (!allow_i && end_raw > exp_end) ? exp_end : end_raw;
   end

   assign strobe_o = busy_i && (tl_i >= beg_t) && (tl_i < end_t);
endmodule

// File: rtl/gsx_line_scan.sv
module gsx_line_scan #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [CW-1:0] lines_i,
   input  logic [CW-1:0] pix_i,
   input  logic [CW-1:0] hblk_i,
   output logic          hsync_o,
   output logic          last_o
);
   logic [CW:0]   period, pcnt;
   logic [CW-1:0] lcnt;
   logic          wrap;

   assign period  = {1'b0, pix_i} + {1'b0, hblk_i};
   assign wrap    = (pcnt == period - 1'b1);
   assign last_o  = run_i && wrap && (lcnt == lines_i - 1'b1);
   assign hsync_o = run_i && (pcnt < {1'b0, pix_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         lcnt <= '0;
      end else if (!run_i) begin
         pcnt <= '0;
         lcnt <= '0;
      end else if (wrap) begin
         pcnt <= '0;
         lcnt <= lcnt + 1'b1;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/gsx_seq.sv
module gsx_seq import gsx_pkg::*; #(
   parameter int CW          = 16,
   parameter int OVW         = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              fsync_i,
   input  logic              cfg_we_i,
   input  logic [REG_AW-1:0] cfg_addr_i,
   input  logic [CW-1:0]     cfg_wdata_i,
   output logic              expo_o,
   output logic              exp_start_o,
   output logic              exp_stop_o,
   output logic              rd_xfer_o,
   output logic              vsync_o,
   output logic              hsync_o,
   output logic              strobe_o,
   output logic              busy_o,
   output logic              ovr_flag_o,
   output logic [OVW-1:0]    ovr_cnt_o
);
   localparam int TLW = CW + 3;

   if (OVW < 1) begin : g_bad_ovw
      $error("gsx_seq: OVW must be at least 1");
   end

   logic trig_rise, fs_rise;
   logic stg_free, stg_fsrc, stg_lead, act_allow;
   logic [CW-1:0] stg_per, act_exp, act_hold, act_soff, act_swid;
   logic [CW-1:0] act_lines, act_pix, act_hblk;
   logic [CW:0]   lead;
   logic [CW-1:0] per_cnt;
   logic          tick, start_ev, busy, load, scan_last, scan_hs, strb;

   gsx_phase_e     ph_q;
   logic [CW:0]    pcnt_q;
   logic [TLW-1:0] tl_q;
   logic           first_q;
   logic           ovr_flag_q;
   logic [OVW-1:0] ovr_cnt_q;

   gsx_sync #(.STAGES(SYNC_STAGES)) trig_sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(trig_i), .rise_o(trig_rise));

   gsx_sync #(.STAGES(SYNC_STAGES)) fs_sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(fsync_i), .rise_o(fs_rise));

   gsx_regs #(.CW(CW)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .load_i(load),
      .stg_free_o(stg_free), .stg_fsrc_o(stg_fsrc), .stg_per_o(stg_per),
      .stg_lead_o(stg_lead), .act_allow_o(act_allow),
      .act_exp_o(act_exp), .act_hold_o(act_hold), .act_soff_o(act_soff),
      .act_swid_o(act_swid), .act_lines_o(act_lines), .act_pix_o(act_pix),
      .act_hblk_o(act_hblk));

   // internal frame period for free-running mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    per_cnt <= '0;
      else if (!stg_free)            per_cnt <= '0;
      else if (per_cnt >= stg_per - 1'b1) per_cnt <= '0;
      else                           per_cnt <= per_cnt + 1'b1;
   end

   assign tick     = stg_free && (per_cnt >= stg_per - 1'b1);
   assign start_ev = stg_free ? tick : (stg_fsrc ? fs_rise : trig_rise);
   assign busy     = (ph_q != PH_IDLE);
   assign load     = start_ev && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         pcnt_q  <= '0;
         tl_q    <= '0;
         first_q <= 1'b0;
      end else begin
         first_q <= 1'b0;
         pcnt_q  <= pcnt_q + 1'b1;
         if (busy && tl_q != '1) tl_q <= tl_q + 1'b1;
         unique case (ph_q)
            PH_IDLE: if (start_ev) begin
               ph_q    <= stg_lead ? PH_LEAD : PH_EXPO;
               pcnt_q  <= '0;
               tl_q    <= '0;
               first_q <= 1'b1;
            end
            PH_LEAD: if (pcnt_q == lead - 1'b1) begin
               ph_q    <= PH_EXPO;
               pcnt_q  <= '0;
               first_q <= 1'b1;
            end
            PH_EXPO: if (pcnt_q == {1'b0, act_exp} - 1'b1) begin
               ph_q    <= PH_HOLD;
               pcnt_q  <= '0;
               first_q <= 1'b1;
            end
            PH_HOLD: if (pcnt_q == {1'b0, act_hold} - 1'b1) begin
               ph_q    <= PH_READ;
               pcnt_q  <= '0;
               first_q <= 1'b1;
            end
            PH_READ: if (scan_last) begin
               ph_q   <= PH_IDLE;
               pcnt_q <= '0;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_flag_q <= 1'b0;
         ovr_cnt_q  <= '0;
      end else if (start_ev && busy) begin
         ovr_flag_q <= 1'b1;
         if (ovr_cnt_q != '1) ovr_cnt_q <= ovr_cnt_q + 1'b1;
      end
   end

   gsx_line_scan #(.CW(CW)) scan_i (
      .clk(clk), .rst_n(rst_n), .run_i(ph_q == PH_READ),
      .lines_i(act_lines), .pix_i(act_pix), .hblk_i(act_hblk),
      .hsync_o(scan_hs), .last_o(scan_last));

   gsx_strobe #(.CW(CW), .TLW(TLW)) strobe_i (
      .tl_i(tl_q), .busy_i(busy), .exp_len_i(act_exp), .soff_i(act_soff),
      .swid_i(act_swid), .allow_i(act_allow), .lead_o(lead), .strobe_o(strb));

   assign expo_o      = (ph_q == PH_EXPO);
   assign exp_start_o = (ph_q == PH_EXPO) && first_q;
   assign exp_stop_o  = (ph_q == PH_HOLD) && first_q;
   assign rd_xfer_o   = (ph_q == PH_READ) && first_q;
   assign vsync_o     = (ph_q == PH_READ);
   assign hsync_o     = scan_hs;
   assign strobe_o    = strb;
   assign busy_o      = busy;
   assign ovr_flag_o  = ovr_flag_q;
   assign ovr_cnt_o   = ovr_cnt_q;
endmodule

// File: rtl/gsx_seq_chk.sv
module gsx_seq_chk #(
   parameter int OVW = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           expo,
   input logic           exp_start,
   input logic           exp_stop,
   input logic           rd_xfer,
   input logic           vsync,
   input logic           hsync,
   input logic           strobe,
   input logic           busy,
   input logic           ovr_flag,
   input logic [OVW-1:0] ovr_cnt,
   input logic           allow
);
   // R3
   start_in_expo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_start |-> expo);

   // R2
   expo_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(expo) |-> exp_stop);

   // R4
   frame_opens_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync) |-> rd_xfer);

   // R4
   line_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |-> vsync);

   // R7
   strobe_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(expo) && !allow) |-> !strobe);

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag |=> ovr_flag);

   // R8
   ovr_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ovr_cnt >= $past(ovr_cnt));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!expo && !vsync && !strobe));
endmodule

bind gsx_seq gsx_seq_chk #(.OVW(OVW)) chk_i (
   .clk(clk), .rst_n(rst_n), .expo(expo_o), .exp_start(exp_start_o),
   .exp_stop(exp_stop_o), .rd_xfer(rd_xfer_o), .vsync(vsync_o),
   .hsync(hsync_o), .strobe(strobe_o), .busy(busy_o),
   .ovr_flag(ovr_flag_o), .ovr_cnt(ovr_cnt_o), .allow(act_allow));

// File: tb/gsx_seq_tb.sv
module gsx_seq_tb_top;
   localparam int CW  = 16;
   localparam int OVW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig = 1'b0;
   logic fsync = 1'b0;
   logic we = 1'b0;
   logic [3:0] addr = '0;
   logic [CW-1:0] wdata = '0;
   logic expo, exp_start, exp_stop, rd_xfer, vsync, hsync, strobe, busy, ovr_flag;
   logic [OVW-1:0] ovr_cnt;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gsx_seq #(.CW(CW), .OVW(OVW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .fsync_i(fsync),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .expo_o(expo), .exp_start_o(exp_start), .exp_stop_o(exp_stop),
      .rd_xfer_o(rd_xfer), .vsync_o(vsync), .hsync_o(hsync),
      .strobe_o(strobe), .busy_o(busy), .ovr_flag_o(ovr_flag),
      .ovr_cnt_o(ovr_cnt));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      we = 1'b1; addr = 4'(a); wdata = CW'(d);
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic set_frame(input int e, input int h, input int off, input int w,
                            input int n, input int p, input int b, input int mode);
      wr(1, e); wr(2, h); wr(3, off); wr(4, w);
      wr(5, n); wr(6, p); wr(7, b); wr(0, mode);
   endtask

   // expected {expo, exp_start, exp_stop, rd_xfer, vsync, hsync, strobe, busy}
   function automatic logic [7:0] model(input int c, input int e, input int h,
         input int off, input int w, input int n, input int p, input int b, input bit allow);
      int ee, hh, nn, pp, lead, rs, lp, tot, sb, se;
      logic [7:0] v;
      ee = (e == 0) ? 1 : e;  hh = (h == 0) ? 1 : h;
      nn = (n == 0) ? 1 : n;  pp = (p == 0) ? 1 : p;
      lead = (off < 0) ? -off : 0;
      rs = lead + ee + hh;  lp = pp + b;  tot = rs + nn * lp;
      sb = (off < 0) ? 0 : off;  se = sb + w;
      if (!allow && se > lead + ee) se = lead + ee;
      v[7] = (c >= lead) && (c < lead + ee);
      v[6] = (c == lead);
      v[5] = (c == lead + ee);
      v[4] = (c == rs);
      v[3] = (c >= rs) && (c < tot);
      v[2] = v[3] && (((c - rs) % lp) < pp);
      v[1] = (c >= sb) && (c < se) && (c < tot);
      v[0] = (c < tot);
      return v;
   endfunction

   task automatic run_seq(input string req, input int e, input int h, input int off,
         input int w, input int n, input int p, input int b, input bit allow, input bit via_fs);
      logic [7:0] got, exp;
      int tot;
      tot = ((off < 0) ? -off : 0) + ((e == 0) ? 1 : e) + ((h == 0) ? 1 : h)
            + ((n == 0) ? 1 : n) * (((p == 0) ? 1 : p) + b);
      @(negedge clk);
      if (via_fs) fsync = 1'b1; else trig = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check({req, " R1 no start before latency"}, int'(busy), 0);
      for (int c = 0; c <= tot + 1; c++) begin
         @(negedge clk);
         got = {expo, exp_start, exp_stop, rd_xfer, vsync, hsync, strobe, busy};
         exp = model(c, e, h, off, w, n, p, b, allow);
         n_chk++;
         if (got !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual=%b expected=%b", req, c, got, exp);
         end
      end
      trig = 1'b0; fsync = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R12 expo", int'(expo), 0);
      check("R12 strobe", int'(strobe), 0);
      check("R12 vsync/hsync", int'(vsync | hsync), 0);
      check("R12 pulses", int'(exp_start | exp_stop | rd_xfer), 0);
      check("R12 busy", int'(busy), 0);
      check("R12 ovr_cnt", int'(ovr_cnt), 0);
      check("R12 ovr_flag", int'(ovr_flag), 0);
   endtask

   task automatic t_basic();
      set_frame(6, 4, 2, 3, 3, 4, 2, 0);
      run_seq("R2 R3 R4 R5 basic", 6, 4, 2, 3, 3, 4, 2, 1'b0, 1'b0);
   endtask

   task automatic t_trunc();
      set_frame(6, 2, 4, 10, 1, 3, 1, 0);
      run_seq("R7 truncated", 6, 2, 4, 10, 1, 3, 1, 1'b0, 1'b0);
      set_frame(6, 2, 4, 10, 1, 3, 1, 4);
      run_seq("R7 allow overrun", 6, 2, 4, 10, 1, 3, 1, 1'b1, 1'b0);
      set_frame(4, 2, 0, 40, 1, 2, 1, 4);
      run_seq("R7 allow capped at end", 4, 2, 0, 40, 1, 2, 1, 1'b1, 1'b0);
   endtask

   task automatic t_negative();
      set_frame(4, 3, -3, 5, 2, 2, 1, 0);
      run_seq("R6 negative offset", 4, 3, -3, 5, 2, 2, 1, 1'b0, 1'b0);
   endtask

   task automatic t_zero();
      set_frame(0, 0, 0, 1, 0, 0, 2, 0);
      run_seq("R2 zero lengths", 0, 0, 0, 1, 0, 0, 2, 1'b0, 1'b0);
   endtask

   task automatic t_shadow();
      set_frame(8, 2, 0, 2, 1, 2, 1, 0);
      @(negedge clk); trig = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 start", int'(exp_start), 1);
      wr(1, 3);
      repeat (5) @(negedge clk);
      check("R11 old length kept", int'(expo), 1);
      @(negedge clk);
      check("R11 old length ends", int'(expo), 0);
      trig = 1'b0;
      repeat (12) @(negedge clk);
      check("R11 idle", int'(busy), 0);
      run_seq("R11 new length", 3, 2, 0, 2, 1, 2, 1, 1'b0, 1'b0);
   endtask

   task automatic t_overrun();
      set_frame(20, 2, 0, 0, 1, 2, 1, 0);
      @(negedge clk); trig = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 started", int'(expo), 1);
      trig = 1'b0;
      repeat (3) @(negedge clk);
      trig = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 count before", int'(ovr_cnt), 0);
      @(negedge clk);
      check("R8 count", int'(ovr_cnt), 1);
      check("R8 flag", int'(ovr_flag), 1);
      check("R8 no restart pulse", int'(exp_start), 0);
      repeat (13) @(negedge clk);
      check("R8 exposure intact", int'(expo), 1);
      @(negedge clk);
      check("R8 exposure ends on time", int'(expo), 0);
      trig = 1'b0;
      repeat (10) @(negedge clk);
      check("R8 idle", int'(busy), 0);
      check("R8 flag sticky", int'(ovr_flag), 1);
   endtask

   task automatic t_fsync();
      set_frame(5, 2, 1, 2, 2, 3, 1, 2);
      @(negedge clk); trig = 1'b1;
      repeat (6) @(negedge clk);
      check("R9 trigger ignored", int'(busy), 0);
      trig = 1'b0;
      repeat (3) @(negedge clk);
      run_seq("R9 frame-sync start", 5, 2, 1, 2, 2, 3, 1, 1'b0, 1'b1);
   endtask

   task automatic t_free();
      set_frame(3, 2, 0, 1, 1, 2, 1, 0);
      wr(8, 20);
      wr(0, 1);
      repeat (19) @(negedge clk);
      check("R10 no early start", int'(exp_start), 0);
      @(negedge clk);
      check("R10 first start", int'(exp_start), 1);
      repeat (19) @(negedge clk);
      check("R10 no early repeat", int'(exp_start), 0);
      @(negedge clk);
      check("R10 second start", int'(exp_start), 1);
      repeat (10) @(negedge clk);
      wr(0, 0);
      repeat (30) @(negedge clk);
      check("R10 stops when cleared", int'(busy), 0);
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_trunc();
      t_negative();
      t_zero();
      t_shadow();
      t_overrun();
      t_fsync();
      t_free();
      finish_up();
   end
endmodule